// File: doc/BRIEF.md
# CAN Controller Operating Mode Manager

This block decides which of three operating modes a CAN controller core is in: initialization, normal or sleep. Software asks for a mode by writing two request bits in a control register. The block shows the mode it has actually reached through two acknowledge bits in a status register, and software polls those bits until the field matches its request. A mode change completes only when the bus allows it. Leaving a quiet mode (initialization or sleep) needs a run of idle bit times. Entering a quiet mode from normal waits until no frame is in progress, which is signalled by the bus-idle input.

The block also holds the bit-timing register and a set of option enables. Both are protected: they accept writes only while initialization is acknowledged. The block keeps two sticky interrupt flags, a wakeup flag and a sleep-entered flag, and software clears them by writing one. When the automatic wakeup option is enabled, bus activity seen during sleep withdraws the sleep request in hardware, so the core returns to normal without software.

Top module: `can_mode_mgr`

## Requirements
- R1: After reset, the control register reads 0x00000001, the status register reads 0x00000001 and the timing register reads 0x01230000. Register addresses are 0 for control, 1 for status and 2 for timing.
- R2: Status bits 1:0 form the acknowledged mode: 01 is initialization, 10 is sleep and 00 is normal. The value 11 never appears.
- R3: Control bit 0 requests initialization and takes priority over control bit 1. When the block is in normal mode and the bus is idle, initialization is acknowledged on the clock edge after the request is registered.
- R4: Entering initialization or sleep from normal mode is held off for as long as busIdle is low.
- R5: Leaving initialization or sleep completes on the edge after busIdle has stayed high across 11 bitTick cycles. A cycle with busIdle low restarts that count.
- R6: Control bit 1 requests sleep. Clearing it while sleep is acknowledged is a wakeup request, and status bit 1 then drops after the idle window of R5.
- R7: Timing register fields are mode 31:30, jump width 25:24, phase segment two 22:20, phase segment one 19:16 and prescaler-minus-one 9:0. All other bits read 0. Writes are ignored unless initialization is acknowledged.
- R8: Control bits 7:2 are option enables: transmit order 2, receive lock 3, no retransmit 4, auto wakeup 5, auto bus-off 6 and time-triggered 7. They change only while initialization is acknowledged. The debug-freeze bit 16 is writable in any mode.
- R9: With auto wakeup (control bit 5) set, busActive during acknowledged sleep clears control bit 1 and sets the wakeup flag, status bit 3. With that option clear, busActive in sleep has no effect.
- R10: The sleep flag, status bit 4, is set when sleep becomes acknowledged. Writing one to status bit 3 or bit 4 clears that flag, and writing zero leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| busIdle | input | 1 | High when no frame is in progress on the bus |
| busActive | input | 1 | Bus activity detected (wakeup source) |
| bitTick | input | 1 | One-cycle pulse per nominal bit time |

## Verification
The assertions take for granted the following about the inputs:
- bitTick is a single-cycle pulse.
- busIdle reflects the bus framing, so a quiet bus stays idle long enough for a pending transition to finish.
- busActive is sampled only as a level during sleep.

The stimulus holds to these assumptions. It raises bitTick for one cycle at a time. It drops busIdle only for deliberate single-cycle glitches or while holding off an entry. It pulses busActive for one cycle only while sleep is acknowledged.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_INIT   = 2'b01,
    MODE_SLEEP  = 2'b10
  } modeT;

  typedef struct packed {
    logic hwWake;
    logic sleepEntered;
  } strobeT;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_TIME = 2'd2;

  localparam int OPT_LO      = 2;
  localparam int OPT_W       = 6;
  localparam int AUTOWAKE_IX = 3;
  localparam int FREEZE_BIT  = 16;
  localparam int WAKEF_BIT   = 3;
  localparam int SLEEPF_BIT  = 4;

endpackage

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int IDLE_BITS = 11
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   initReq,
  input  logic   sleepReq,
  input  logic   autoWake,
  input  logic   busIdle,
  input  logic   busActive,
  input  logic   bitTick,
  output modeT   curMode,
  output strobeT strobe
);
  localparam int CNT_W = $clog2(IDLE_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_BITS);

  modeT targetMode;
  logic [CNT_W-1:0] idleCnt;
  logic leaveOk;
  logic moveNow;

  always_comb begin
    if (initReq)       targetMode = MODE_INIT;
    else if (sleepReq) targetMode = MODE_SLEEP;
    else               targetMode = MODE_NORMAL;
  end

  assign leaveOk = busIdle && (idleCnt >= CNT_MAX);
  assign moveNow = (curMode != targetMode) &&
                   ((curMode == MODE_NORMAL) ? busIdle : leaveOk);

  always_comb begin
    strobe.sleepEntered = moveNow && (targetMode == MODE_SLEEP);
    strobe.hwWake = (curMode == MODE_SLEEP) && autoWake && busActive && sleepReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMode <= MODE_INIT;
      idleCnt <= '0;
    end else begin
      if (moveNow) curMode <= targetMode;
      if (curMode == targetMode || !busIdle || moveNow)
        idleCnt <= '0;
      else if (bitTick && idleCnt < CNT_MAX)
        idleCnt <= idleCnt + 1'b1;
    end
  end

endmodule

// File: rtl/can_mode_regs.sv
module can_mode_regs
  import can_mode_pkg::*;
#(
  parameter int          PRESC_W  = 10,
  parameter logic [31:0] TIME_RST = 32'h0123_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  input  modeT        curMode,
  input  strobeT      strobe,
  output logic [31:0] rdata,
  output logic        initReq,
  output logic        sleepReq,
  output logic        autoWake
);
  localparam logic [31:0] TIME_MASK = 32'hC37F_0000 | ((32'd1 << PRESC_W) - 32'd1);

  logic [OPT_W-1:0] opts;
  logic             freeze;
  logic             wakeFlag;
  logic             sleepFlag;
  logic [31:0]      timing;
  logic             initAck;
  logic             wrCtrl, wrStat, wrTime;

  assign initAck  = (curMode == MODE_INIT);
  assign autoWake = opts[AUTOWAKE_IX];
  assign wrCtrl   = wrEn && (addr == ADDR_CTRL);
  assign wrStat   = wrEn && (addr == ADDR_STAT);
  assign wrTime   = wrEn && (addr == ADDR_TIME);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initReq   <= 1'b1;
      sleepReq  <= 1'b0;
      opts      <= '0;
      freeze    <= 1'b0;
      wakeFlag  <= 1'b0;
      sleepFlag <= 1'b0;
      timing    <= TIME_RST & TIME_MASK;
    end else begin
      if (wrCtrl) begin
        initReq  <= wdata[0];
        sleepReq <= wdata[1];
        freeze   <= wdata[FREEZE_BIT];
        if (initAck) opts <= wdata[OPT_LO +: OPT_W];
      end
      if (strobe.hwWake) sleepReq <= 1'b0;
      if (wrTime && initAck) timing <= wdata & TIME_MASK;

      if (strobe.hwWake)                wakeFlag <= 1'b1;
      else if (wrStat && wdata[WAKEF_BIT]) wakeFlag <= 1'b0;

      if (strobe.sleepEntered)            sleepFlag <= 1'b1;
      else if (wrStat && wdata[SLEEPF_BIT]) sleepFlag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CTRL: begin
        rdata[0]                 = initReq;
        rdata[1]                 = sleepReq;
        rdata[OPT_LO +: OPT_W]   = opts;
        rdata[FREEZE_BIT]        = freeze;
      end
      ADDR_STAT: begin
        rdata[1:0]               = curMode;
        rdata[WAKEF_BIT]         = wakeFlag;
        rdata[SLEEPF_BIT]        = sleepFlag;
      end
      ADDR_TIME: rdata = timing;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/can_mode_mgr.sv
module can_mode_mgr
  import can_mode_pkg::*;
#(
  parameter int IDLE_BITS = 11,
  parameter int PRESC_W   = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        busIdle,
  input  logic        busActive,
  input  logic        bitTick
);
  modeT   curMode;
  strobeT strobe;
  logic   initReq, sleepReq, autoWake;

  can_mode_ctrl #(.IDLE_BITS(IDLE_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .initReq(initReq), .sleepReq(sleepReq),
    .autoWake(autoWake), .busIdle(busIdle), .busActive(busActive),
    .bitTick(bitTick), .curMode(curMode), .strobe(strobe)
  );

  can_mode_regs #(.PRESC_W(PRESC_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .curMode(curMode), .strobe(strobe), .rdata(rdata),
    .initReq(initReq), .sleepReq(sleepReq), .autoWake(autoWake)
  );

endmodule

// File: rtl/can_mode_chk.sv
module can_mode_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busIdle,
  input logic        busActive,
  input logic [1:0]  modeAck,
  input logic        wakeFlag,
  input logic        sleepFlag,
  input logic [31:0] timing,
  input logic [5:0]  opts
);
  // R2
  mode_field_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(modeAck) <= 1);

  // R4
  entry_waits_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeAck == 2'b00 && !busIdle) |=> modeAck == 2'b00);

  // R5
  exit_needs_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeAck != 2'b00 && !busIdle) |=> modeAck == $past(modeAck));

  // R7
  timing_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeAck != 2'b01) |=> $stable(timing));

  // R8
  options_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeAck != 2'b01) |=> $stable(opts));

  // R9
  wake_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeFlag) |-> ($past(busActive) && $past(modeAck) == 2'b10));

  // R10
  sleep_flag_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepFlag) |-> (modeAck == 2'b10 && $past(modeAck) != 2'b10));

endmodule

bind can_mode_mgr can_mode_chk u_chk (
  .clk(clk), .rstN(rstN), .busIdle(busIdle), .busActive(busActive),
  .modeAck(curMode), .wakeFlag(u_regs.wakeFlag), .sleepFlag(u_regs.sleepFlag),
  .timing(u_regs.timing), .opts(u_regs.opts)
);

// File: tb/sim_can_mode_mgr.sv
module sim_can_mode_mgr;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busIdle = 1'b1;
  logic        busActive = 1'b0;
  logic        bitTick = 1'b0;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_TIME = 2'd2;

  // {written value, expected readback} for the timing register (R7)
  localparam logic [63:0] TIME_VEC [6] = '{
    {32'hFFFF_FFFF, 32'hC37F_03FF},
    {32'h0000_0000, 32'h0000_0000},
    {32'h4012_0010, 32'h4012_0010},
    {32'h8C80_0400, 32'h8000_0000},
    {32'h0323_4567, 32'h0323_0167},
    {32'hA5A5_A5A5, 32'h8125_01A5}
  };

  always #2 clk = ~clk;

  can_mode_mgr u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .busIdle(busIdle), .busActive(busActive), .bitTick(bitTick)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [1:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); bitTick = 1'b1;
      @(negedge clk); bitTick = 1'b0;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1 reset values
    rdchk("R1 ctrl", A_CTRL, 32'h0000_0001);
    rdchk("R1 stat", A_STAT, 32'h0000_0001);
    rdchk("R1 time", A_TIME, 32'h0123_0000);

    // R7 timing field masking while init is acknowledged
    for (int i = 0; i < 6; i++) begin
      wr(A_TIME, TIME_VEC[i][63:32]);
      rdchk("R7 table", A_TIME, TIME_VEC[i][31:0]);
    end

    // R8 options and freeze writable during init
    wr(A_CTRL, 32'h0001_00FD);
    rdchk("R8 opts in init", A_CTRL, 32'h0001_00FD);

    // R5 leave init: counting, glitch restart, exact completion
    wr(A_CTRL, 32'h0001_00FC);
    cyc(5);
    rdchk("R5 no ticks", A_STAT, 32'h1);
    ticks(10);
    rdchk("R5 ten ticks", A_STAT, 32'h1);
    @(negedge clk); busIdle = 1'b0;
    @(negedge clk); busIdle = 1'b1;
    ticks(10);
    rdchk("R5 restart after glitch", A_STAT, 32'h1);
    ticks(1);
    rdchk("R5 before edge", A_STAT, 32'h1);
    cyc(1);
    rdchk("R5 R2 normal", A_STAT, 32'h0);

    // R7 and R8 locked in normal; freeze still writable
    wr(A_TIME, 32'h0);
    rdchk("R7 locked", A_TIME, 32'h8125_01A5);
    wr(A_CTRL, 32'h0);
    rdchk("R8 locked", A_CTRL, 32'h0000_00FC);

    // R4 entry held while bus busy, R3 completes once idle
    busIdle = 1'b0;
    wr(A_CTRL, 32'h0000_00FD);
    cyc(5);
    rdchk("R4 held", A_STAT, 32'h0);
    busIdle = 1'b1;
    cyc(1);
    rdchk("R3 init ack", A_STAT, 32'h1);

    // R6 R10 init -> sleep
    wr(A_CTRL, 32'h0000_00FE);
    ticks(11);
    cyc(1);
    rdchk("R6 R10 sleep ack", A_STAT, 32'h12);
    wr(A_STAT, 32'h0);
    rdchk("R10 write zero", A_STAT, 32'h12);
    wr(A_STAT, 32'h10);
    rdchk("R10 w1c", A_STAT, 32'h02);

    // R9 automatic wakeup
    @(negedge clk); busActive = 1'b1;
    @(negedge clk); busActive = 1'b0;
    rdchk("R9 req cleared", A_CTRL, 32'h0000_00FC);
    rdchk("R9 wake flag", A_STAT, 32'h0A);
    ticks(11);
    cyc(1);
    rdchk("R9 back to normal", A_STAT, 32'h08);
    wr(A_STAT, 32'h08);
    rdchk("R10 wake w1c", A_STAT, 32'h0);

    // R8 options ignored when written from normal
    wr(A_CTRL, 32'h1);
    rdchk("R8 ignored", A_CTRL, 32'h0000_00FD);
    cyc(1);
    rdchk("R3 init again", A_STAT, 32'h1);
    wr(A_CTRL, 32'h1);
    rdchk("R8 cleared in init", A_CTRL, 32'h1);
    wr(A_CTRL, 32'h2);
    ticks(11);
    cyc(1);
    rdchk("R6 sleep", A_STAT, 32'h12);

    // R9 disabled: activity has no effect
    @(negedge clk); busActive = 1'b1;
    @(negedge clk); busActive = 1'b0;
    rdchk("R9 off ctrl", A_CTRL, 32'h2);
    rdchk("R9 off stat", A_STAT, 32'h12);
    wr(A_STAT, 32'h10);

    // R6 software wakeup
    wr(A_CTRL, 32'h0);
    ticks(10);
    rdchk("R6 still asleep", A_STAT, 32'h02);
    ticks(1);
    cyc(1);
    rdchk("R6 woke", A_STAT, 32'h0);

    // R3 init priority over sleep
    wr(A_CTRL, 32'h3);
    cyc(1);
    rdchk("R3 priority", A_STAT, 32'h1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule